// File: doc/BRIEF.md
# ADC Power-Mode and Warm-Up Controller

This block is the digital control for a successive-approximation A/D converter. Software drives two control bits: a comparator-enable and a conversion-start. From these the block derives a registered power mode (off, comparator-only idle, or converting). It also times a fixed-length sampling phase and a fixed-length conversion phase, and it raises a one-cycle result strobe at the end of every conversion. Conversions repeat back to back for as long as the start bit stays high.

A counter measures how long the comparator has been powered since enable rose. If a conversion starts before the comparator has settled, the block marks the first result of that run as stale. Software should then discard that result.

A 3-bit rate select sets the phase lengths in clock cycles. Rate codes that would break the minimum-sampling or maximum-conversion limits raise a configuration error, and the start bit is then ignored.

Top module: `adc_mode_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `pwr_mode_o` is 2'b00, and `busy_o`, `sampling_o`, `res_valid_o`, `res_stale_o` and `settled_o` are 0.
- R2: One clock after the clock edge that samples enable=0 and start=0, `pwr_mode_o` is 2'b00 (off).
- R3: One clock after the clock edge that samples enable=1 and start=0, `pwr_mode_o` is 2'b01 (comparator-only idle).
- R4: One clock after the clock edge that samples start=1 with an allowed rate code, `pwr_mode_o` is 2'b10 (converting) and `busy_o` is 1. This holds whatever the value of enable.
- R5: `settled_o` goes high on the 8th consecutive clock edge that samples enable=1. It then stays high while enable stays 1, and it clears on the first edge that samples enable=0.
- R6: The first result of a run has `res_stale_o`=1 when start is first sampled high fewer than 8 edges after enable was first sampled high (this includes enable being low). Otherwise it has `res_stale_o`=0. Later results of the same run always have `res_stale_o`=0.
- R7: For rate code c, the sample length is 4*(c+1) cycles and the total conversion length is 4*(c+1)+8 cycles. A code is prohibited when its sample length is below 8 or its total is 36 or more, so codes 0, 6 and 7 are prohibited. `cfg_err_o` follows the code combinationally.
- R8: While the rate code is prohibited, start is ignored: `busy_o` stays 0, no result is produced, and the mode follows the enable bit.
- R9: `res_valid_o` is a one-cycle pulse. It appears T clock edges after the edge that starts a run, where T is the total length, and then every further T edges while start stays high.
- R10: Within each conversion, `sampling_o` is high for exactly the first S cycles, where S is the sample length, and low for the rest.
- R11: Clearing start aborts a conversion: one edge later `busy_o` is 0, and no `res_valid_o` pulse comes from the aborted conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_en_i | input | 1 | Comparator-enable control bit |
| conv_go_i | input | 1 | Conversion-start control bit |
| rate_sel_i | input | 3 | Rate code selecting the phase lengths |
| pwr_mode_o | output | 2 | Power mode: 00 off, 01 idle, 10 converting |
| settled_o | output | 1 | Comparator warm-up time has elapsed |
| cfg_err_o | output | 1 | Rate code is prohibited |
| busy_o | output | 1 | A conversion run is in progress |
| sampling_o | output | 1 | Current conversion is in its sampling phase |
| res_valid_o | output | 1 | One-cycle end-of-conversion strobe |
| res_stale_o | output | 1 | The strobed result is the stale first result |

## Verification
The bench targets the warm-up boundary. It starts a run 7 edges after enable and then 8 edges after enable. A design with an off-by-one settle counter would swap the stale flag in one of those two cases. A design that never resets the counter would miss the case where enable is dropped and raised again.

Start is also driven with enable low, to check that start overrides enable. A decoder that gave priority to enable would report idle in that case.

The bench also checks that a prohibited code blocks start and that dropping start mid-run produces no strobe. A design that ignored either would show `busy_o` or a stray `res_valid_o`. Strobe and sampling timing are checked cycle by cycle at two rate codes, so a wrong phase length shifts a sample edge and is caught.

// File: rtl/adcm_pkg.sv
// Shared types for the ADC mode controller.
// Assumes a two-bit power-mode encoding that downstream analog enables decode directly.
package adcm_pkg;
    typedef enum logic [1:0] {
        PM_OFF  = 2'b00,
        PM_IDLE = 2'b01,
        PM_CONV = 2'b10
    } pmode_t;
endpackage

// File: rtl/adcm_settle_timer.sv
// Comparator warm-up timer: counts clock edges while enable is high,
// saturates at SETTLE_CYCLES, and clears on any edge with enable low.
// Assumes SETTLE_CYCLES equals the settling time expressed in peripheral clocks.
module adcm_settle_timer #(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic settled_o
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count enabled cycles, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign settled_o = (cnt_q == LIMIT);

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_o && en_i) |=> settled_o); // R5
    AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !settled_o); // R5
endmodule

// File: rtl/adcm_rate_decode.sv
// Rate decoder: turns the rate code into sample and total phase lengths
// and flags codes that break the minimum-sample or maximum-total limit.
// Purely combinational; assumes LEN_W holds the largest total length.
module adcm_rate_decode #(
    parameter int SEL_W      = 3,
    parameter int SAMP_UNIT  = 4,
    parameter int CONV_EXTRA = 8,
    parameter int MIN_SAMPLE = 8,
    parameter int MAX_TOTAL  = 36,
    parameter int LEN_W      = 6
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LEN_W-1:0] sample_len_o,
    output logic [LEN_W-1:0] total_len_o,
    output logic             prohibited_o
);
    int samp_c;
    int tot_c;

    // Compute phase lengths and the legality of the selected code.
    always_comb begin
        samp_c       = SAMP_UNIT * (int'(sel_i) + 1);
        tot_c        = samp_c + CONV_EXTRA;
        sample_len_o = LEN_W'(samp_c);
        total_len_o  = LEN_W'(tot_c);
        prohibited_o = (samp_c < MIN_SAMPLE) || (tot_c >= MAX_TOTAL);
    end
endmodule

// File: rtl/adcm_conv_seq.sv
// Conversion sequencer: while start is high and not blocked, runs
// back-to-back conversions of total_len_i cycles, the first sample_len_i of
// which are sampling, and strobes a result at each end. The first result of
// a run is tagged stale if the comparator was unsettled when the run began.
// Assumes total_len_i >= 2 and stays constant during a run.
module adcm_conv_seq #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             blocked_i,
    input  logic             settled_i,
    input  logic [LEN_W-1:0] sample_len_i,
    input  logic [LEN_W-1:0] total_len_i,
    output logic             busy_o,
    output logic             sampling_o,
    output logic             res_valid_o,
    output logic             res_stale_o
);
    logic             running_q;
    logic             first_q;
    logic             unsettled_q;
    logic [LEN_W-1:0] cnt_q;
    logic             valid_q;
    logic             stale_q;

    // Run, count and strobe conversions; abort silently when start drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q   <= 1'b0;
            first_q     <= 1'b0;
            unsettled_q <= 1'b0;
            cnt_q       <= '0;
            valid_q     <= 1'b0;
            stale_q     <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            stale_q <= 1'b0;
            if (!go_i || blocked_i) begin
                running_q   <= 1'b0;
                first_q     <= 1'b0;
                unsettled_q <= 1'b0;
                cnt_q       <= '0;
            end else if (!running_q) begin
                running_q   <= 1'b1;
                first_q     <= 1'b1;
                unsettled_q <= !settled_i;
                cnt_q       <= '0;
            end else if (cnt_q >= total_len_i - 1'b1) begin
                valid_q <= 1'b1;
                stale_q <= first_q && unsettled_q;
                first_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o      = running_q;
    assign sampling_o  = running_q && (cnt_q < sample_len_i);
    assign res_valid_o = valid_q;
    assign res_stale_o = stale_q;

    AST_STALE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_stale_o |-> res_valid_o); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R9
    AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sampling_o |-> busy_o); // R10
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (!busy_o && !res_valid_o)); // R11
endmodule

// File: rtl/adc_mode_ctrl.sv
// ADC power-mode and warm-up controller (top). Decodes the enable/start
// control bits into a registered power mode (start overrides enable), times
// comparator warm-up, checks the rate code and runs the conversion sequencer.
// Assumes control inputs are already synchronous to clk.
module adc_mode_ctrl #(
    parameter int SEL_W         = 3,
    parameter int SETTLE_CYCLES = 8,
    parameter int SAMP_UNIT     = 4,
    parameter int CONV_EXTRA    = 8,
    parameter int MIN_SAMPLE    = 8,
    parameter int MAX_TOTAL     = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comp_en_i,
    input  logic             conv_go_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    output logic [1:0]       pwr_mode_o,
    output logic             settled_o,
    output logic             cfg_err_o,
    output logic             busy_o,
    output logic             sampling_o,
    output logic             res_valid_o,
    output logic             res_stale_o
);
    import adcm_pkg::*;

    localparam int LEN_W = $clog2(SAMP_UNIT * (2 ** SEL_W) + CONV_EXTRA + 1);

    logic [LEN_W-1:0] sample_len;
    logic [LEN_W-1:0] total_len;
    logic             prohibited;
    logic             settled;
    pmode_t           mode_q;
    logic             past_ok_q;

    adcm_rate_decode #(
        .SEL_W(SEL_W), .SAMP_UNIT(SAMP_UNIT), .CONV_EXTRA(CONV_EXTRA),
        .MIN_SAMPLE(MIN_SAMPLE), .MAX_TOTAL(MAX_TOTAL), .LEN_W(LEN_W)
    ) u_rate (
        .sel_i(rate_sel_i), .sample_len_o(sample_len),
        .total_len_o(total_len), .prohibited_o(prohibited)
    );

    adcm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .en_i(comp_en_i), .settled_o(settled)
    );

    adcm_conv_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(conv_go_i), .blocked_i(prohibited),
        .settled_i(settled), .sample_len_i(sample_len), .total_len_i(total_len),
        .busy_o(busy_o), .sampling_o(sampling_o),
        .res_valid_o(res_valid_o), .res_stale_o(res_stale_o)
    );

    // Register the power mode; an accepted start wins over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= PM_OFF;
        else if (conv_go_i && !prohibited)
            mode_q <= PM_CONV;
        else if (comp_en_i)
            mode_q <= PM_IDLE;
        else
            mode_q <= PM_OFF;
    end

    // Mark cycles where the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_ok_q <= 1'b0;
        else
            past_ok_q <= 1'b1;
    end

    assign pwr_mode_o = mode_q;
    assign settled_o  = settled;
    assign cfg_err_o  = prohibited;

    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!comp_en_i && !conv_go_i) |=> (pwr_mode_o == 2'b00)); // R2
    AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_en_i && !conv_go_i) |=> (pwr_mode_o == 2'b01)); // R3
    AST_MODE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go_i && !cfg_err_o) |=> (pwr_mode_o == 2'b10 && busy_o)); // R4
    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(cfg_err_o)) |-> !busy_o); // R8
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode_o != 2'b11); // R2
endmodule

// File: tb/adc_mode_ctrl_tb_top.sv
// Directed bench for adc_mode_ctrl: one task per scenario, each checking its results.
module adc_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       go = 1'b0;
    logic [2:0] sel = 3'd1;
    logic [1:0] mode;
    logic       settled, cerr, busy, samp, rvalid, rstale;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .comp_en_i(en), .conv_go_i(go),
        .rate_sel_i(sel), .pwr_mode_o(mode), .settled_o(settled),
        .cfg_err_o(cerr), .busy_o(busy), .sampling_o(samp),
        .res_valid_o(rvalid), .res_stale_o(rstale)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_all(int n);
        @(negedge clk); en = 1'b0; go = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mode", int'(mode), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 valid", int'(rvalid), 0);
        check("R1 settled", int'(settled), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode after release", int'(mode), 0);
        check("R1 sampling", int'(samp) + int'(rstale), 0);
    endtask

    task automatic t_modes();
        sel = 3'd1; en = 1'b1; go = 1'b0;
        @(negedge clk); check("R3 idle mode", int'(mode), 1);
        en = 1'b0; go = 1'b1;
        @(negedge clk); check("R4 conv without enable", int'(mode), 2);
        check("R4 busy", int'(busy), 1);
        en = 1'b1;
        @(negedge clk); check("R4 conv with enable", int'(mode), 2);
        en = 1'b0; go = 1'b0;
        @(negedge clk); check("R2 off mode", int'(mode), 0);
        check("R11 busy after stop", int'(busy), 0);
    endtask

    task automatic t_settle();
        idle_all(2);
        en = 1'b1;
        repeat (7) @(negedge clk);
        check("R5 not settled after 7", int'(settled), 0);
        @(negedge clk); check("R5 settled after 8", int'(settled), 1);
        repeat (5) @(negedge clk);
        check("R5 holds", int'(settled), 1);
        en = 1'b0;
        @(negedge clk); check("R5 clears", int'(settled), 0);
    endtask

    task automatic t_rate_table();
        for (int c = 0; c < 8; c++) begin
            sel = 3'(c);
            #1;
            check("R7 cfg_err code", int'(cerr),
                  ((4 * (c + 1) < 8) || (4 * (c + 1) + 8 >= 36)) ? 1 : 0);
        end
        sel = 3'd1;
    endtask

    // Run one conversion pair at code c and check every cycle's timing.
    task automatic t_conv(int c, logic with_en);
        int s = 4 * (c + 1);
        int t = s + 8;
        idle_all(2);
        sel = 3'(c); en = with_en; go = 1'b1;
        for (int k = 1; k <= 2 * t + 1; k++) begin
            @(negedge clk);
            if (k == 1) check("R4 conv mode", int'(mode), 2);
            if (k <= t) check("R10 sampling phase", int'(samp), (k <= s) ? 1 : 0);
            check("R9 strobe timing", int'(rvalid), (k == t + 1 || k == 2 * t + 1) ? 1 : 0);
        end
        go = 1'b0;
    endtask

    // Start d edges after enable and check the first/second stale flags.
    task automatic t_stale(int d, int exp_first, logic en_on);
        idle_all(2);
        sel = 3'd1; en = en_on;
        repeat (d) @(negedge clk);
        go = 1'b1;
        repeat (17) @(negedge clk);
        check("R6 first valid", int'(rvalid), 1);
        check("R6 first stale", int'(rstale), exp_first);
        repeat (16) @(negedge clk);
        check("R6 second valid", int'(rvalid), 1);
        check("R6 second not stale", int'(rstale), 0);
        go = 1'b0;
    endtask

    task automatic t_abort();
        int seen = 0;
        idle_all(2);
        sel = 3'd2; en = 1'b1; go = 1'b1;
        repeat (6) @(negedge clk);
        go = 1'b0;
        @(negedge clk); check("R11 busy cleared", int'(busy), 0);
        for (int k = 0; k < 30; k++) begin
            if (rvalid) seen++;
            @(negedge clk);
        end
        check("R11 no strobe after abort", seen, 0);
    endtask

    task automatic t_prohibited();
        int seen = 0;
        idle_all(2);
        sel = 3'd0; en = 1'b1; go = 1'b1;
        #1; check("R8 cfg_err code 0", int'(cerr), 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (busy || rvalid) seen++;
        end
        check("R8 start ignored", seen, 0);
        check("R8 mode follows enable", int'(mode), 1);
        sel = 3'd7; en = 1'b0;
        @(negedge clk); check("R8 mode off code 7", int'(mode), 0);
        check("R8 busy code 7", int'(busy), 0);
        go = 1'b0; sel = 3'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_modes();
        t_settle();
        t_rate_table();
        t_conv(1, 1'b1);
        t_conv(2, 1'b0);
        t_stale(0, 1, 1'b1);
        t_stale(7, 1, 1'b1);
        t_stale(8, 0, 1'b1);
        t_stale(12, 1, 1'b0);
        t_abort();
        t_prohibited();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule